// File: doc/BRIEF.md
# UART Receiver with Error Status

This block is the receive half of an asynchronous serial port. It watches a serial line with a 16x oversampling tick, finds start bits, shifts in eight data bits least significant first and, depending on its configuration, one extra ninth bit that carries either parity or a multi-processor address marker. It then samples a stop bit. A finished frame either goes into a one-entry receive buffer or, if that buffer still holds unread data, is thrown away and reported as an overrun.

For every frame it sets an error status byte: parity error, framing error and overrun. In multi-processor mode it also records whether the ninth bit marked the frame as an address. The host reads the data and status through a small register read port. A one-cycle completion pulse tells it that a frame has ended, whether the frame was kept or dropped.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status byte reads 00h and the data register reads 00h. Status bits 7 to 4 always read 0. Bit 3 is the multi-processor marker, bit 2 the parity error, bit 1 the framing error and bit 0 the overrun.
- R2: A falling edge on the line is accepted as a start bit only if the line is still low 8 oversample ticks later. A shorter low pulse is ignored and produces no frame. The eight data bits are sampled at mid-bit, LSB first.
- R3: `cfg_parity` selects the ninth bit: 00 means no parity bit, 01 means the parity bit must be 0, 10 means odd parity and 11 means even parity. A mismatch sets status bit 2.
- R4: A stop bit sampled low sets status bit 1. The frame's data is still stored.
- R5: With `cfg_two_stop` set, only the first stop bit is checked. The line is then ignored for one more bit time, so a low second stop bit causes neither an error nor a new frame.
- R6: A frame that ends while the buffer holds unread data sets status bit 0, and its data is discarded. The buffer keeps its old contents.
- R7: Every further frame before the buffer is read is again an overrun. The first frame after a data read is stored, and bit 0 is cleared.
- R8: With `cfg_mp_mode` set, the ninth bit is the multi-processor marker. Status bit 3 follows its value and parity is not checked. With the mode off, bit 3 keeps its value.
- R9: While `cfg_enable` is 0, status bits 3 to 0 read 0 and the receiver produces no frames.
- R10: `rx_done` pulses high for exactly one clock for every completed frame, whether it is stored or discarded.
- R11: `rd_addr` 0 selects the data register and 1 the status byte. Only a read strobe with address 0 frees the buffer. A status read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_serial | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| cfg_enable | input | 1 | Receiver enable; 0 clears the status flags |
| cfg_parity | input | 2 | Parity mode (00 none, 01 zero, 10 odd, 11 even) |
| cfg_two_stop | input | 1 | Two stop bits in the frame |
| cfg_mp_mode | input | 1 | Ninth bit is a multi-processor marker |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 data register, 1 status byte |
| rd_data | output | 8 | Selected register value |
| rx_done | output | 1 | Frame-completion pulse |

## Verification
The embedded assertions watch rules that hold on every cycle. The completion pulse never lasts two cycles. A disabled receiver stays idle with its flags clear. An overrun never changes the buffer. An accepted frame always leaves the buffer full with that frame's data. The marker flag holds still outside multi-processor mode. Other behaviours only show up in the bench's serial waveforms: rejecting a short start glitch, the meaning of each parity mode, the guard time after a low second stop bit, and overruns repeating until the data register is read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP,
        RX_GUARD
    } rx_state_e;

    localparam int STAT_MP = 3;
    localparam int STAT_PE = 2;
    localparam int STAT_FE = 1;
    localparam int STAT_OV = 0;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              os_tick,
    input  logic              rx_s,
    input  logic              has_ninth,
    input  logic              two_stop,
    output logic              frame_valid,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_ninth,
    output logic              frame_stop_ok
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              ninth;
        logic              prev;
        logic              valid;
        logic              stop_ok;
    } deser_t;

    deser_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (!enable) begin
            r_d.st  = RX_IDLE;
            r_d.cnt = '0;
            if (os_tick) r_d.prev = rx_s;
        end else if (os_tick) begin
            r_d.prev = rx_s;
            unique case (r_q.st)
                RX_IDLE: begin
                    if (r_q.prev && !rx_s) begin
                        r_d.st  = RX_START;
                        r_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (r_q.cnt == MID_CNT) begin
                        r_d.cnt = '0;
                        if (!rx_s) begin
                            r_d.st  = RX_DATA;
                            r_d.idx = '0;
                        end else begin
                            r_d.st = RX_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt = '0;
                        r_d.sh  = {rx_s, r_q.sh[DATA_W-1:1]};
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st = has_ninth ? RX_NINTH : RX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_NINTH: begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt   = '0;
                        r_d.ninth = rx_s;
                        r_d.st    = RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt     = '0;
                        r_d.stop_ok = rx_s;
                        r_d.valid   = 1'b1;
                        r_d.st      = two_stop ? RX_GUARD : RX_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_GUARD: begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt = '0;
                        r_d.st  = RX_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= RX_IDLE;
            r_q.prev    <= 1'b1;
            r_q.stop_ok <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_valid   = r_q.valid;
    assign frame_data    = r_q.sh;
    assign frame_ninth   = r_q.ninth;
    assign frame_stop_ok = r_q.stop_ok;

    // R10: a frame is reported for a single cycle only
    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |=> !r_q.valid);

    // R9: a disabled receiver is held idle
    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (r_q.st == RX_IDLE));

    // R2: data reception only begins after a low start sample
    p_start_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_DATA && $past(r_q.st) == RX_START) |-> !$past(rx_s));

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        parity,
    input  logic              mp_mode,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_ninth,
    input  logic              frame_stop_ok,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] buf_data,
    output logic [7:0]        status,
    output logic              done
);

    typedef struct packed {
        logic [DATA_W-1:0] buffer;
        logic              full;
        logic              mp;
        logic              pe;
        logic              fe;
        logic              ov;
        logic              done;
    } regs_t;

    regs_t g_d, g_q;

    logic      rd_clr;
    logic      overrun;
    logic      parity_bad;
    par_mode_e pmode;

    always_comb begin
        pmode   = par_mode_e'(parity);
        rd_clr  = rd_en && !rd_addr;
        overrun = g_q.full && !rd_clr;
        unique case (pmode)
            PAR_NONE: parity_bad = 1'b0;
            PAR_ZERO: parity_bad = frame_ninth;
            PAR_ODD:  parity_bad = ~(^frame_data ^ frame_ninth);
            PAR_EVEN: parity_bad = ^frame_data ^ frame_ninth;
            default:  parity_bad = 1'b0;
        endcase
    end

    always_comb begin
        g_d      = g_q;
        g_d.done = 1'b0;
        if (rd_clr) g_d.full = 1'b0;
        if (frame_valid) begin
            g_d.done = 1'b1;
            g_d.ov   = overrun;
            g_d.fe   = !frame_stop_ok;
            g_d.pe   = mp_mode ? 1'b0 : parity_bad;
            if (mp_mode) g_d.mp = frame_ninth;
            if (!overrun) begin
                g_d.buffer = frame_data;
                g_d.full   = 1'b1;
            end
        end
        if (!enable) begin
            g_d.mp = 1'b0;
            g_d.pe = 1'b0;
            g_d.fe = 1'b0;
            g_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    always_comb begin
        status          = 8'h00;
        status[STAT_MP] = g_q.mp;
        status[STAT_PE] = g_q.pe;
        status[STAT_FE] = g_q.fe;
        status[STAT_OV] = g_q.ov;
    end

    assign buf_data = g_q.buffer;
    assign done     = g_q.done;

    // R6: a discarded frame never touches the buffer
    p_ovr_keeps_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && g_q.full && !rd_clr) |=> $stable(g_q.buffer));

    // R7: an accepted frame leaves the buffer full with its data
    p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !g_q.full) |=> (g_q.full && g_q.buffer == $past(frame_data)));

    // R8: the marker flag holds while the mode is off
    p_mp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !mp_mode) |=> $stable(g_q.mp));

    // R9: disabling clears every flag
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (status[3:0] == 4'h0));

    // R10: completion pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.done |=> !g_q.done);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_serial,
    input  logic       os_tick,
    input  logic       cfg_enable,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic       cfg_mp_mode,
    input  logic       rd_en,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       rx_done
);

    logic              rx_s;
    logic              has_ninth;
    logic              f_valid;
    logic [DATA_W-1:0] f_data;
    logic              f_ninth;
    logic              f_stop_ok;
    logic [DATA_W-1:0] buf_data;
    logic [7:0]        status;

    assign has_ninth = cfg_mp_mode || (par_mode_e'(cfg_parity) != PAR_NONE);

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_serial),
        .dout (rx_s)
    );

    uart_rx_deser #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .os_tick      (os_tick),
        .rx_s         (rx_s),
        .has_ninth    (has_ninth),
        .two_stop     (cfg_two_stop),
        .frame_valid  (f_valid),
        .frame_data   (f_data),
        .frame_ninth  (f_ninth),
        .frame_stop_ok(f_stop_ok)
    );

    uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (cfg_enable),
        .parity       (cfg_parity),
        .mp_mode      (cfg_mp_mode),
        .frame_valid  (f_valid),
        .frame_data   (f_data),
        .frame_ninth  (f_ninth),
        .frame_stop_ok(f_stop_ok),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .buf_data     (buf_data),
        .status       (status),
        .done         (rx_done)
    );

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr) rd_data = status;
        else         rd_data[DATA_W-1:0] = buf_data;
    end

endmodule

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_serial = 1'b1;
    logic       os_tick;
    logic       cfg_enable = 1'b1;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_mp_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       rx_done;

    logic [1:0] tcnt = 2'd0;
    int         done_cnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign os_tick = (tcnt == 2'd3);

    always @(posedge clk) if (rx_done) done_cnt <= done_cnt + 1;

    uart_rx_status uut (
        .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .os_tick(os_tick),
        .cfg_enable(cfg_enable), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_mp_mode(cfg_mp_mode), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rx_done(rx_done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rx_serial = v;
        repeat (64) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit has9, input bit b9,
                        input bit stop1, input bit low2);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(d[i]);
        if (has9) bit_time(b9);
        bit_time(stop1);
        if (low2) bit_time(1'b0);
        bit_time(1'b1);
        bit_time(1'b1);
    endtask

    task automatic peek(input logic addr, input bit strobe, output logic [7:0] v);
        @(negedge clk);
        rd_addr = addr;
        rd_en   = strobe;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // sends one frame, checks exactly one completion pulse, status and data register
    task automatic frame(input string req, input logic [7:0] d, input bit has9, input bit b9,
                         input bit stop1, input bit low2,
                         input logic [7:0] exp_stat, input logic [7:0] exp_data);
        int n0;
        logic [7:0] v;
        n0 = done_cnt;
        send(d, has9, b9, stop1, low2);
        chk({req, " R10 pulse count"}, 8'(done_cnt - n0), 8'd1);
        peek(1'b1, 1'b0, v);
        chk({req, " status"}, v, exp_stat);
        peek(1'b0, 1'b0, v);
        chk({req, " data"}, v, exp_data);
    endtask

    task automatic drain();
        logic [7:0] v;
        peek(1'b0, 1'b1, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(1'b1, 1'b0, v);  chk("R1 status after reset", v, 8'h00);
        peek(1'b0, 1'b0, v);  chk("R1 data after reset", v, 8'h00);
        chk("R10 no pulse after reset", 8'(done_cnt), 8'd0);
    endtask

    task automatic t_basic();
        cfg_parity = 2'b00;
        frame("R2 basic A5", 8'hA5, 0, 0, 1, 0, 8'h00, 8'hA5);
        drain();
        frame("R2 basic 3C", 8'h3C, 0, 0, 1, 0, 8'h00, 8'h3C);
        drain();
    endtask

    task automatic t_false_start();
        int n0;
        logic [7:0] v;
        n0 = done_cnt;
        rx_serial = 1'b0;
        repeat (12) @(negedge clk);
        rx_serial = 1'b1;
        repeat (16 * 64) @(negedge clk);
        chk("R2 glitch gives no frame", 8'(done_cnt - n0), 8'd0);
        peek(1'b1, 1'b0, v);
        chk("R2 glitch status", v, 8'h00);
    endtask

    task automatic t_parity();
        cfg_parity = 2'b10;
        frame("R3 odd good", 8'h01, 1, 0, 1, 0, 8'h00, 8'h01); drain();
        frame("R3 odd bad",  8'h01, 1, 1, 1, 0, 8'h04, 8'h01); drain();
        cfg_parity = 2'b11;
        frame("R3 even good", 8'h03, 1, 0, 1, 0, 8'h00, 8'h03); drain();
        frame("R3 even bad",  8'h03, 1, 1, 1, 0, 8'h04, 8'h03); drain();
        cfg_parity = 2'b01;
        frame("R3 zero good", 8'h7E, 1, 0, 1, 0, 8'h00, 8'h7E); drain();
        frame("R3 zero bad",  8'h7E, 1, 1, 1, 0, 8'h04, 8'h7E); drain();
        cfg_parity = 2'b00;
    endtask

    task automatic t_framing();
        frame("R4 stop low", 8'hC3, 0, 0, 0, 0, 8'h02, 8'hC3); drain();
        frame("R4 clears next frame", 8'h81, 0, 0, 1, 0, 8'h00, 8'h81); drain();
    endtask

    task automatic t_two_stop();
        cfg_two_stop = 1'b1;
        frame("R5 low second stop", 8'h5A, 0, 0, 1, 1, 8'h00, 8'h5A); drain();
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        frame("R6 first kept", 8'h11, 0, 0, 1, 0, 8'h00, 8'h11);
        frame("R6 overrun", 8'h22, 0, 0, 1, 0, 8'h01, 8'h11);
        frame("R7 overrun again", 8'h33, 0, 0, 1, 0, 8'h01, 8'h11);
        peek(1'b0, 1'b1, v);
        chk("R7 read returns old data", v, 8'h11);
        frame("R7 after read", 8'h44, 0, 0, 1, 0, 8'h00, 8'h44);
        drain();
    endtask

    task automatic t_status_read();
        logic [7:0] v;
        frame("R11 load", 8'h55, 0, 0, 1, 0, 8'h00, 8'h55);
        peek(1'b1, 1'b1, v);
        chk("R11 status read value", v, 8'h00);
        frame("R11 status read keeps buffer full", 8'h66, 0, 0, 1, 0, 8'h01, 8'h55);
        drain();
    endtask

    task automatic t_mp();
        cfg_mp_mode = 1'b1;
        cfg_parity  = 2'b10;
        frame("R8 marker one, no parity check", 8'h01, 1, 1, 1, 0, 8'h08, 8'h01); drain();
        frame("R8 marker zero", 8'h02, 1, 0, 1, 0, 8'h00, 8'h02); drain();
        frame("R8 marker one again", 8'h04, 1, 1, 1, 0, 8'h08, 8'h04); drain();
        cfg_mp_mode = 1'b0;
        cfg_parity  = 2'b00;
        frame("R8 marker held with mode off", 8'h08, 0, 0, 1, 0, 8'h08, 8'h08); drain();
    endtask

    task automatic t_disable();
        int n0;
        logic [7:0] v;
        frame("R9 setup flags", 8'h10, 0, 0, 0, 0, 8'h0A, 8'h10); drain();
        cfg_enable = 1'b0;
        repeat (4) @(negedge clk);
        peek(1'b1, 1'b0, v);
        chk("R9 flags cleared when disabled", v, 8'h00);
        n0 = done_cnt;
        send(8'h77, 0, 0, 1, 0);
        chk("R9 no frame when disabled", 8'(done_cnt - n0), 8'd0);
        cfg_enable = 1'b1;
        bit_time(1'b1);
        frame("R9 works after enable", 8'h99, 0, 0, 1, 0, 8'h00, 8'h99); drain();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_false_start();
        t_parity();
        t_framing();
        t_two_stop();
        t_overrun();
        t_status_read();
        t_mp();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule